// File: doc/BRIEF.md
# Burst Address Sequencer for an AHB-Lite Master

This block drives the address phase of an AHB-Lite master. A requester hands it one burst description: start address, direction, transfer size and burst kind. The block then puts out the address, transfer type, size, burst kind, direction and a fixed protection code, one beat at a time. A beat moves forward only on a clock edge where the bus ready input is high.

The block covers single transfers and incrementing bursts of 4, 8 and 16 beats. It also covers wrapping bursts of 4, 8 and 16 beats and incrementing bursts of open length. During a burst the requester can ask for master BUSY cycles. For an open-length burst, the requester holds a continue input high for as long as more beats are wanted.

The block checks each request before it starts the burst. A request is refused if its size is wider than the 32-bit data bus, if its start address is not aligned to the size, or if it is a fixed-length incrementing burst that would cross a 1 KB address boundary. A refused request gives a one-cycle error pulse and starts no bus transfer.

Top module: `ahb_burst_addr_gen`

## Requirements
- R1: Out of reset, and whenever no burst is active, the transfer type is IDLE (2'b00). The request-ready output is high while no burst is active and bus ready is high. A request is taken on a clock edge where both request-valid and request-ready are high.
- R2: Transfer types use IDLE=2'b00, BUSY=2'b01, NONSEQ=2'b10 and SEQ=2'b11. The first beat of every burst, including a single transfer, is NONSEQ, and every later beat is SEQ.
- R3: In an incrementing burst, each beat's address is the previous beat's address plus 2^size bytes. Size codes are 0=byte, 1=halfword and 2=word.
- R4: In a wrapping burst, the address wraps inside an aligned window of (2^size × beats) bytes. For example, a 4-beat word wrap from 0x34 gives 0x34, 0x38, 0x3C, 0x30.
- R5: Burst kind codes are 000 single, 001 open incrementing, 010 wrap4, 011 incr4, 100 wrap8, 101 incr8, 110 wrap16 and 111 incr16. A burst issues exactly that many beats and then returns to IDLE.
- R6: The size, burst kind and direction outputs equal the request's values and stay constant for the whole burst.
- R7: While bus ready is low, every address-phase output holds its value.
- R8: If the BUSY request is high on the edge that issues a beat that is not the last, the next cycle is BUSY and already shows the next beat's address. After the BUSY cycles the burst resumes with SEQ at that same address.
- R9: An open incrementing burst goes on while the continue input is high on each issuing edge. It ends after the beat issued on an edge where continue is low.
- R10: An open incrementing burst also ends, with no further beat, when the next address would fall on a 1 KB boundary.
- R11: A fixed-length incrementing request whose last byte lies past the 1 KB boundary is refused: the error output pulses for one cycle after the request edge, and the bus stays IDLE. A burst that ends exactly on the boundary is accepted.
- R12: A request with a size code above 2, or with a start address not aligned to its size, is refused in the same way as in R11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Reset, active low |
| req_valid | input | 1 | Burst request present |
| req_addr | input | AW | Start address of the request |
| req_write | input | 1 | Request direction, 1 = write |
| req_size | input | 3 | Request transfer size code |
| req_kind | input | 3 | Request burst kind code |
| req_ready | output | 1 | Block can take a request this cycle |
| req_err | output | 1 | One-cycle pulse for a refused request |
| busy_req | input | 1 | Ask for a BUSY cycle after the current beat |
| incr_more | input | 1 | Continue an open-length incrementing burst |
| bus_ready | input | 1 | Bus ready; the address phase advances when high |
| bus_addr | output | AW | Address-phase address |
| bus_trans | output | 2 | Transfer type |
| bus_size | output | 3 | Transfer size |
| bus_kind | output | 3 | Burst kind |
| bus_write | output | 1 | Transfer direction |
| bus_prot | output | 4 | Constant protection code |

## Verification
The bench sweeps every fixed burst kind at every legal size, from several start addresses. One start sits in the middle of a wrap window, and another makes a 16-beat word burst end exactly on a 1 KB boundary. These sweeps separate incrementing address arithmetic from wrapping arithmetic, and they show whether the wrap mask depends on size as well as beat count. The same sweep adds BUSY cycles and bus wait states at chosen beats. This shows that BUSY already shows the next address and that a stall freezes every output. Open-length bursts are ended both by the continue input and by the boundary. The refusal cases cover an over-boundary incrementing burst, an oversized transfer and misaligned starts.

// File: rtl/ahb_burst_addr_gen.sv
module ahb_burst_addr_gen #(
  parameter int AW = 32,
  parameter logic [3:0] PROT = 4'b0011
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic          req_write,
  input  logic [2:0]    req_size,
  input  logic [2:0]    req_kind,
  output logic          req_ready,
  output logic          req_err,
  input  logic          busy_req,
  input  logic          incr_more,
  input  logic          bus_ready,
  output logic [AW-1:0] bus_addr,
  output logic [1:0]    bus_trans,
  output logic [2:0]    bus_size,
  output logic [2:0]    bus_kind,
  output logic          bus_write,
  output logic [3:0]    bus_prot
);
  localparam logic [1:0] T_IDLE = 2'b00;
  localparam logic [1:0] T_BUSY = 2'b01;
  localparam logic [1:0] T_NSEQ = 2'b10;
  localparam logic [1:0] T_SEQ  = 2'b11;
  localparam logic [2:0] K_OPEN = 3'b001;

  logic          active, open_len;
  logic [3:0]    left;
  logic [AW-1:0] step, span_m1, next_addr;
  logic          is_wrap, last, take;
  logic [4:0]    req_beats;
  logic [11:0]   end_off;
  logic          misalign, crosses, req_bad;

  assign bus_prot  = PROT;
  assign req_ready = !active && bus_ready;
  assign take      = req_valid && req_ready;

  assign step      = AW'(1) << bus_size;
  assign is_wrap   = !bus_kind[0] && (bus_kind != 3'b000);
  assign span_m1   = (step << ({1'b0, bus_kind[2:1]} + 3'd1)) - AW'(1);
  assign next_addr = is_wrap ? ((bus_addr & ~span_m1) | ((bus_addr + step) & span_m1))
                             : (bus_addr + step);
  assign last      = open_len ? (!incr_more || (next_addr[9:0] == 10'd0)) : (left == 4'd0);

  assign req_beats = (req_kind[2:1] == 2'b00) ? 5'd1 : (5'd2 << req_kind[2:1]);
  assign end_off   = {2'b00, req_addr[9:0]} + ({7'd0, req_beats} << req_size[1:0]);
  assign misalign  = (req_size == 3'd1 && req_addr[0]) || (req_size == 3'd2 && req_addr[1:0] != 2'b00);
  assign crosses   = req_kind[0] && (req_kind != K_OPEN) && (end_off > 12'd1024);
  assign req_bad   = (req_size > 3'd2) || misalign || crosses;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active    <= 1'b0;
      open_len  <= 1'b0;
      left      <= '0;
      req_err   <= 1'b0;
      bus_addr  <= '0;
      bus_trans <= T_IDLE;
      bus_size  <= '0;
      bus_kind  <= '0;
      bus_write <= 1'b0;
    end else begin
      req_err <= take && req_bad;
      if (bus_ready) begin
        if (!active) begin
          if (take && !req_bad) begin
            active    <= 1'b1;
            open_len  <= (req_kind == K_OPEN);
            left      <= 4'(req_beats - 5'd1);
            bus_addr  <= req_addr;
            bus_trans <= T_NSEQ;
            bus_size  <= req_size;
            bus_kind  <= req_kind;
            bus_write <= req_write;
          end
        end else if (bus_trans == T_BUSY) begin
          if (!busy_req) bus_trans <= T_SEQ;
        end else if (last) begin
          active    <= 1'b0;
          open_len  <= 1'b0;
          bus_addr  <= '0;
          bus_trans <= T_IDLE;
          bus_size  <= '0;
          bus_kind  <= '0;
          bus_write <= 1'b0;
        end else begin
          bus_addr  <= next_addr;
          left      <= left - 4'd1;
          bus_trans <= busy_req ? T_BUSY : T_SEQ;
        end
      end
    end
  end

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_ready |=> $stable(bus_addr) && $stable(bus_trans) && $stable(bus_size)
                   && $stable(bus_kind) && $stable(bus_write));

  // R3
  incr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_trans == T_SEQ && bus_kind[0] && $past(bus_ready) && $past(bus_trans[1]))
      |-> bus_addr == $past(bus_addr) + (AW'(1) << bus_size));

  // R6
  ctrl_const_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_trans == T_SEQ || bus_trans == T_BUSY)
      |-> $stable(bus_size) && $stable(bus_kind) && $stable(bus_write));

  // R10
  no_kb_cross_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_trans == T_SEQ || bus_trans == T_BUSY) |-> bus_addr[AW-1:10] == $past(bus_addr[AW-1:10]));

  // R11
  reject_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |-> bus_trans == T_IDLE);

  // R12
  size_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_trans != T_IDLE |-> bus_size <= 3'd2);
endmodule

// File: tb/ahb_burst_addr_gen_tb_top.sv
module ahb_burst_addr_gen_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, busy_req = 1'b0, incr_more = 1'b0, bus_ready = 1'b1;
  logic [31:0] req_addr = '0;
  logic [2:0] req_size = '0, req_kind = '0;
  logic req_ready, req_err, bus_write;
  logic [31:0] bus_addr;
  logic [1:0] bus_trans;
  logic [2:0] bus_size, bus_kind;
  logic [3:0] bus_prot;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ahb_burst_addr_gen dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_write(req_write), .req_size(req_size), .req_kind(req_kind),
    .req_ready(req_ready), .req_err(req_err), .busy_req(busy_req),
    .incr_more(incr_more), .bus_ready(bus_ready), .bus_addr(bus_addr),
    .bus_trans(bus_trans), .bus_size(bus_size), .bus_kind(bus_kind),
    .bus_write(bus_write), .bus_prot(bus_prot));

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] beat_addr(input logic [31:0] start, input int size,
                                            input logic [2:0] kind, input int i);
    int bytes = 1 << size;
    int beats = (kind[2:1] == 0) ? 1 : (2 << kind[2:1]);
    logic [31:0] span;
    if (!kind[0] && kind != 0) begin
      span = bytes * beats;
      return (start & ~(span - 1)) | ((start + i * bytes) & (span - 1));
    end
    return start + i * bytes;
  endfunction

  task automatic run(input logic [31:0] start, input int size, input logic [2:0] kind,
                     input logic wr, input int open_len, input logic [15:0] bp, input logic [15:0] wp);
    int n = (kind == 3'b001) ? open_len : ((kind[2:1] == 0) ? 1 : (2 << kind[2:1]));
    logic [31:0] ea;
    bit lst;
    @(negedge clk);
    req_addr = start; req_size = 3'(size); req_kind = kind; req_write = wr; req_valid = 1'b1;
    chk(req_ready === 1'b1, "R1", "req_ready", 32'(req_ready), 1);
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 20; i++) begin
      ea = beat_addr(start, size, kind, i);
      chk(bus_trans === ((i == 0) ? 2'b10 : 2'b11), "R2", "trans", 32'(bus_trans), (i == 0) ? 2 : 3);
      chk(bus_addr === ea, (!kind[0] && kind != 0) ? "R4" : "R3", "addr", bus_addr, ea);
      chk(bus_size === 3'(size) && bus_kind === kind && bus_write === wr, "R6", "ctrl",
          {25'd0, bus_write, bus_kind, bus_size}, {25'd0, wr, kind, 3'(size)});
      if (wp[i]) begin
        bus_ready = 1'b0;
        @(posedge clk); @(negedge clk);
        chk(bus_addr === ea && bus_trans === ((i == 0) ? 2'b10 : 2'b11), "R7", "stall hold", bus_addr, ea);
        bus_ready = 1'b1;
      end
      lst = (i == n - 1) || (kind == 3'b001 && ((ea + (1 << size)) & 32'h3FF) == 0);
      incr_more = (i < n - 1);
      busy_req = bp[i];
      @(posedge clk); @(negedge clk);
      busy_req = 1'b0;
      if (lst) begin
        chk(bus_trans === 2'b00, (kind == 3'b001) ? ((i == n - 1) ? "R9" : "R10") : "R5",
            "end idle", 32'(bus_trans), 0);
        break;
      end
      if (bp[i]) begin
        chk(bus_trans === 2'b01 && bus_addr === beat_addr(start, size, kind, i + 1), "R8",
            "busy next addr", bus_addr, beat_addr(start, size, kind, i + 1));
        @(posedge clk); @(negedge clk);
      end
    end
  endtask

  task automatic reject(input logic [31:0] a, input int size, input logic [2:0] kind, input string req);
    @(negedge clk);
    req_addr = a; req_size = 3'(size); req_kind = kind; req_valid = 1'b1;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    chk(req_err === 1'b1 && bus_trans === 2'b00, req, "err pulse", {30'd0, req_err, bus_trans[1]}, 2);
    @(posedge clk); @(negedge clk);
    chk(req_err === 1'b0 && bus_trans === 2'b00, req, "err clears", {30'd0, req_err, bus_trans[1]}, 0);
  endtask

  initial begin
    logic [31:0] bases [3] = '{32'h0000_0134, 32'h1234_5006, 32'h8000_03C1};
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(bus_trans === 2'b00 && req_ready === 1'b1 && req_err === 1'b0, "R1", "reset idle",
        {29'd0, req_err, bus_trans}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(bus_trans === 2'b00, "R1", "idle no request", 32'(bus_trans), 0);
    run(32'h0000_0034, 2, 3'b010, 1'b0, 0, 16'h0, 16'h0);
    for (int s = 0; s < 3; s++)
      for (int b = 0; b < 8; b++)
        for (int k = 0; k < 3; k++)
          if (b != 1)
            run(bases[k] & ~((32'd1 << s) - 1), s, 3'(b), k[0], 0,
                (k == 0) ? 16'h0 : ((k == 1) ? 16'h0005 : 16'h0012),
                (k == 0) ? 16'h0 : ((k == 1) ? 16'h0002 : 16'h0009));
    run(32'h0000_0200, 2, 3'b001, 1'b1, 6, 16'h0004, 16'h0001);
    run(32'h0000_0500, 0, 3'b001, 1'b0, 3, 16'h0, 16'h0);
    run(32'h0000_03F8, 2, 3'b001, 1'b0, 6, 16'h0, 16'h0);
    run(32'h0000_07FE, 0, 3'b001, 1'b1, 5, 16'h0, 16'h0);
    run(32'h0000_03F0, 2, 3'b011, 1'b0, 0, 16'h0, 16'h0);
    reject(32'h0000_03F0, 2, 3'b111, "R11");
    reject(32'h0000_03F2, 1, 3'b101, "R11");
    reject(32'h0000_0100, 3, 3'b000, "R12");
    reject(32'h0000_0102, 2, 3'b011, "R12");
    reject(32'h0000_0101, 1, 3'b010, "R12");
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R1 watchdog actual=%h expected=%h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule